// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Interrupt-on-Change

This block is a 16-pin bidirectional general-purpose port made of two 8-pin halves, A (pins 7:0) and B (pins 15:8). A host configures and reads it through a parallel register bus with separate read and write strobes. Each pin can be set as input or output, drives its output latch when it is an output, and can have its input sense inverted. Interrupts are per pin: each can fire on any change from a stored reference, or whenever the pin disagrees with a stored default.

Each half owns one interrupt line. An option ties the two lines so that an event in either half asserts both. The lines can be push-pull active-low, push-pull active-high, or open-drain. In open-drain mode the line only ever drives low, and an enable output tells the pad when to drive. An asynchronous active-low reset returns every register to its default.

Register address: bit 0 selects the half (0 = A, 1 = B) and bits 4:1 select the register: 0 direction (1 = input), 1 polarity invert, 2 interrupt enable, 3 default value, 4 compare mode (1 = against default, 0 = against reference), 5 configuration (shared; bit0 tie lines, bit1 open-drain, bit2 active-high), 6 flag (read-only), 7 capture (read-only), 8 port, 9 output latch. Read data appears on the clock edge after the read strobe.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset, every direction bit reads 1, pin_oe is all zero, pin_out is all zero, and both interrupt lines are idle in push-pull active-low form (irq_x_o = 1, irq_x_oe = 1).
- R2: A pin whose direction bit is 0 has pin_oe high and drives its latch value on pin_out. A write to either the port address or the latch address updates the latch.
- R3: A port read returns the pin value XOR the polarity bit for input pins, taken from a two-stage synchroniser. For output pins it returns the latch value with no inversion.
- R4: In reference mode (compare bit 0), an enabled input pin whose value differs from its reference sets its flag bit and loads the capture register with the port value. The flag is set on the third clock edge after the pin changes. A read of that half's port or capture register clears the flag and loads the reference with the current port value.
- R5: In default mode (compare bit 1), an enabled input pin that differs from its default bit raises the flag. If the mismatch still holds after the clearing read, the flag sets again one edge later.
- R6: A pin whose enable bit is 0 never sets a flag bit.
- R7: While a half's flag is non-zero, its flag and capture registers hold until that half's port or capture register is read. Reading the flag register does not clear it.
- R8: With the tie bit set, an event in either half asserts both interrupt lines.
- R9: In open-drain mode, irq_x_o is always 0 and irq_x_oe equals the line's active state. Otherwise irq_x_oe is 1, and irq_x_o is the active state when active-high is set, or its inverse when it is not.
- R10: Writes to the flag and capture addresses have no effect.
- R11: Asserting rst_n low clears all registers at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one edge after bus_rd |
| pin_in | input | 16 | Pin input levels |
| pin_out | output | 16 | Pin output levels |
| pin_oe | output | 16 | Pin output enables |
| irq_a_o | output | 1 | Half A interrupt level |
| irq_a_oe | output | 1 | Half A interrupt drive enable |
| irq_b_o | output | 1 | Half B interrupt level |
| irq_b_oe | output | 1 | Half B interrupt drive enable |

## Verification
Random direction, polarity, latch and pin values on both halves show whether inversion reaches only the input pins and whether output pins return their latch. Random default-mode trials with random enables and defaults show whether the flag holds exactly the enabled mismatching pins, and whether the capture register holds the port value. Directed single-pin toggles show four things: reference mode against default mode, through the re-fire after a clearing read; that a flag read does not clear; that a capture read does clear; and that masked pins stay silent. Sweeping the configuration bits while one half is pending shows the tied, open-drain and active-high line behaviour.

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port #(
  parameter int HW = 8,
  parameter int AW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [HW-1:0]   bus_wdata,
  output logic [HW-1:0]   bus_rdata,
  input  logic [2*HW-1:0] pin_in,
  output logic [2*HW-1:0] pin_out,
  output logic [2*HW-1:0] pin_oe,
  output logic            irq_a_o,
  output logic            irq_a_oe,
  output logic            irq_b_o,
  output logic            irq_b_oe
);
  localparam int IW = AW - 1;
  localparam logic [IW-1:0] I_DIR = 0, I_POL = 1, I_IEN = 2, I_DFLT = 3, I_MODE = 4,
                            I_CFG = 5, I_FLAG = 6, I_CAP = 7, I_PORT = 8, I_LAT = 9;

  logic [1:0][HW-1:0] dir, pol, ien, dflt, mode, lat, flag, cap, refv, pv, ev;
  logic [2*HW-1:0] sync1, sync2;
  logic [2:0] cfg;
  logic [1:0] clr, act;
  logic [IW-1:0] idx;
  logic hsel;

  assign idx  = bus_addr[AW-1:1];
  assign hsel = bus_addr[0];

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      pv[h]  = (dir[h] & (sync2[h*HW +: HW] ^ pol[h])) | (~dir[h] & lat[h]);
      ev[h]  = ien[h] & dir[h] & ((mode[h] & (pv[h] ^ dflt[h])) | (~mode[h] & (pv[h] ^ refv[h])));
      clr[h] = bus_rd && (hsel == h[0]) && (idx == I_PORT || idx == I_CAP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      cfg   <= '0;
      dir   <= '1;
      pol   <= '0;
      ien   <= '0;
      dflt  <= '0;
      mode  <= '0;
      lat   <= '0;
      flag  <= '0;
      cap   <= '0;
      refv  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      if (bus_wr && idx == I_CFG) cfg <= bus_wdata[2:0];
      for (int h = 0; h < 2; h++) begin
        if (bus_wr && hsel == h[0]) begin
          case (idx)
            I_DIR:         dir[h]  <= bus_wdata;
            I_POL:         pol[h]  <= bus_wdata;
            I_IEN:         ien[h]  <= bus_wdata;
            I_DFLT:        dflt[h] <= bus_wdata;
            I_MODE:        mode[h] <= bus_wdata;
            I_PORT, I_LAT: lat[h]  <= bus_wdata;
            default: ;
          endcase
        end
        if (clr[h]) begin
          flag[h] <= '0;
          refv[h] <= pv[h];
        end else if (flag[h] == '0 && ev[h] != '0) begin
          flag[h] <= ev[h];
          cap[h]  <= pv[h];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (idx)
        I_DIR:   bus_rdata <= dir[hsel];
        I_POL:   bus_rdata <= pol[hsel];
        I_IEN:   bus_rdata <= ien[hsel];
        I_DFLT:  bus_rdata <= dflt[hsel];
        I_MODE:  bus_rdata <= mode[hsel];
        I_CFG:   bus_rdata <= HW'(cfg);
        I_FLAG:  bus_rdata <= flag[hsel];
        I_CAP:   bus_rdata <= cap[hsel];
        I_PORT:  bus_rdata <= pv[hsel];
        I_LAT:   bus_rdata <= lat[hsel];
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign pin_out = lat;
  assign pin_oe  = ~dir;

  assign act[0] = (|flag[0]) | (cfg[0] & (|flag[1]));
  assign act[1] = (|flag[1]) | (cfg[0] & (|flag[0]));

  assign irq_a_o  = cfg[1] ? 1'b0 : (cfg[2] ? act[0] : ~act[0]);
  assign irq_a_oe = cfg[1] ? act[0] : 1'b1;
  assign irq_b_o  = cfg[1] ? 1'b0 : (cfg[2] ? act[1] : ~act[1]);
  assign irq_b_oe = cfg[1] ? act[1] : 1'b1;

  p_clear_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr[0] |=> flag[0] == '0);
  p_clear_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr[1] |=> flag[1] == '0);
  p_irq_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] != '0 && cfg[2:1] == 2'b00) |-> !irq_a_o);
  p_mask_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] == '0) |=> (flag[0] & ~$past(ien[0])) == '0);
  p_mask_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] == '0) |=> (flag[1] & ~$past(ien[1])) == '0);
  p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] != '0 && !clr[0]) |=> (flag[0] == $past(flag[0]) && cap[0] == $past(cap[0])));
  p_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] != '0 && !clr[1]) |=> (flag[1] == $past(flag[1]) && cap[1] == $past(cap[1])));
  p_tied_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && !cfg[1]) |-> irq_a_o == irq_b_o);
endmodule

// File: tb/test_gpio_ioc_port.sv
`timescale 1ns/1ps
module test_gpio_ioc_port;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [15:0] pin_in = 0, pin_out, pin_oe;
  logic irq_a_o, irq_a_oe, irq_b_o, irq_b_oe;
  int n_run = 0, n_fail = 0;
  logic [7:0] v;

  localparam int DIR = 0, POL = 1, IEN = 2, DFLT = 3, MODE = 4, CFG = 5,
                 FLAG = 6, CAP = 7, PORT = 8, LAT = 9;

  gpio_ioc_port i_gpio_ioc_port (.*);

  always #2.5 clk = ~clk;

  function automatic logic [4:0] ad(int idx, int h);
    return 5'(idx * 2 + h);
  endfunction

  function automatic logic [7:0] exp_port(logic [7:0] d, logic [7:0] p, logic [7:0] l, logic [7:0] pin);
    return (d & (pin ^ p)) | (~d & l);
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, int h, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = ad(idx, h); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int idx, int h, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = ad(idx, h);
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    check("R1 irq_a", {irq_a_o, irq_a_oe}, 2'b11);
    check("R1 irq_b", {irq_b_o, irq_b_oe}, 2'b11);
    rd(DIR, 0, v); check("R1 dir_a", v, 8'hFF);
    rd(DIR, 1, v); check("R1 dir_b", v, 8'hFF);

    // R2 direction and latch
    wr(DIR, 0, 8'h0F); wr(LAT, 0, 8'hA5);
    check("R2 pin_oe", pin_oe, 16'h00F0);
    check("R2 pin_out", pin_out, 16'h00A5);
    wr(PORT, 0, 8'h3C);
    check("R2 port write", pin_out[7:0], 8'h3C);

    // R3 polarity on inputs only
    wr(POL, 0, 8'hFF); wr(LAT, 0, 8'hF0); pin_in[7:0] = 8'h05; settle();
    rd(PORT, 0, v); check("R3 directed", v, 8'hFA);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d, p, l, pa;
      int h;
      h = $urandom_range(1, 0);
      d = 8'($urandom); p = 8'($urandom); l = 8'($urandom); pa = 8'($urandom);
      wr(DIR, h, d); wr(POL, h, p); wr(LAT, h, l);
      pin_in[h*8 +: 8] = pa; settle();
      rd(PORT, h, v); check("R3 random", v, exp_port(d, p, l, pa));
    end
    wr(DIR, 0, 8'hFF); wr(DIR, 1, 8'hFF); wr(POL, 0, 0); wr(POL, 1, 0);
    pin_in = 0; settle();
    rd(CAP, 0, v); rd(CAP, 1, v);

    // R4 reference mode on half B, R7 hold
    rd(PORT, 1, v);
    wr(IEN, 1, 8'h01);
    pin_in[8] = 1; settle();
    check("R4 irq_b asserted", irq_b_o, 0);
    check("R4 irq_a idle", irq_a_o, 1);
    rd(FLAG, 1, v); check("R4 flag_b", v, 8'h01);
    rd(FLAG, 1, v); check("R7 flag read keeps", v, 8'h01);
    pin_in[8] = 0; settle();
    check("R7 still pending", irq_b_o, 0);
    rd(CAP, 1, v); check("R4 cap_b", v, 8'h01);
    check("R4 cleared", irq_b_o, 1);
    repeat (2) @(negedge clk);
    check("R4 ref updated", irq_b_o, 1);
    wr(IEN, 1, 0);

    // R5 default mode on half A
    wr(MODE, 0, 8'hFF); wr(DFLT, 0, 8'h00); wr(IEN, 0, 8'h80);
    pin_in[7] = 1; settle();
    check("R5 irq_a asserted", irq_a_o, 0);
    rd(PORT, 0, v); check("R5 port", v, 8'h80);
    check("R5 cleared", irq_a_o, 1);
    @(negedge clk);
    check("R5 refire", irq_a_o, 0);
    pin_in[7] = 0; settle();
    rd(PORT, 0, v); @(negedge clk);
    check("R5 released", irq_a_o, 1);

    // R6 masked pin
    wr(IEN, 0, 8'h01);
    pin_in[7] = 1; repeat (4) @(negedge clk);
    check("R6 irq_a", irq_a_o, 1);
    rd(FLAG, 0, v); check("R6 flag_a", v, 0);
    pin_in[7] = 0; settle();

    // R8 tie, R9 line modes
    wr(CFG, 0, 8'h01); wr(IEN, 0, 8'h80);
    pin_in[7] = 1; settle();
    check("R8 irq_a", irq_a_o, 0);
    check("R8 irq_b", irq_b_o, 0);
    wr(CFG, 0, 8'h02);
    check("R9 od a", {irq_a_o, irq_a_oe}, 2'b01);
    check("R9 od b idle", {irq_b_o, irq_b_oe}, 2'b00);
    wr(CFG, 1, 8'h04);
    check("R9 high a", {irq_a_o, irq_a_oe}, 2'b11);
    check("R9 high b", {irq_b_o, irq_b_oe}, 2'b01);

    // R10 read-only registers
    begin
      logic [7:0] c0, f0;
      rd(CAP, 0, c0); rd(FLAG, 0, f0);
      wr(FLAG, 0, 8'h5A); wr(CAP, 0, 8'h5A);
      rd(FLAG, 0, v); check("R10 flag", v, f0);
      check("R10 flag nonzero", f0, 8'h80);
      wr(IEN, 0, 0); pin_in[7] = 0; settle();
      wr(CAP, 0, 8'h11); wr(FLAG, 0, 8'h11);
      rd(CAP, 0, v); check("R10 cap", v, c0);
    end
    wr(CFG, 0, 0);

    // R5 random default-mode trials
    for (int i = 0; i < 40; i++) begin
      logic [7:0] p, df, en, pa, pvx, ex;
      int h;
      h = $urandom_range(1, 0);
      p = 8'($urandom); df = 8'($urandom); en = 8'($urandom); pa = 8'($urandom);
      wr(IEN, h, 0); rd(CAP, h, v);
      wr(MODE, h, 8'hFF); wr(POL, h, p); wr(DFLT, h, df);
      pin_in[h*8 +: 8] = pa; settle();
      wr(IEN, h, en); @(negedge clk);
      pvx = pa ^ p; ex = en & (pvx ^ df);
      rd(FLAG, h, v); check("R5 random flag", v, ex);
      if (ex != 0) begin
        rd(CAP, h, v); check("R4 random cap", v, pvx);
      end else begin
        check("R6 random idle", h ? irq_b_o : irq_a_o, 1);
      end
      wr(IEN, h, 0); rd(CAP, h, v);
    end

    // R11 asynchronous reset
    wr(DIR, 0, 8'h00); wr(LAT, 0, 8'h3C);
    #1 rst_n = 0; #0.5;
    check("R11 oe async", pin_oe, 0);
    check("R11 out async", pin_out, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    rd(DIR, 0, v); check("R11 dir_a", v, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule